// File: doc/BRIEF.md
# Converter Result Queue with Output Coding

This block sits between an analog-to-digital converter and a host register interface. Each 12-bit conversion result is pushed into a 16-entry first-in first-out queue. The host pops one result per read strobe and gets back a 16-bit word. A coding-select input chooses the form of that word: plain straight binary, or a signed two's complement value that is sign-extended to the full width. The coding is applied at the moment of the read, so a change of the select input also changes how results that are already queued come out.

Two status outputs go with the queue. The first is a data-available bit, high while at least one result is waiting. The second is a sticky overflow bit, which records that a result was lost because the queue was full. The overflow bit stays set until the host strobes the clear input. After a clear, the next read strobe is a dummy read: it returns no data and empties the queue, so the host starts again from a known state.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset, rd_word is 0x0000, data_avail is 0 and ovf_flag is 0.
- R2: Results are returned in the order they were written. Up to 16 results can be held. data_avail is 1 exactly when at least one result is stored. A successful read updates rd_word on the clock edge at which rd_strobe is sampled.
- R3: A write while 16 results are stored and no read is served sets ovf_flag. The incoming result is discarded, and the 16 stored results stay unchanged and in order.
- R4: ovf_flag is sticky. It stays 1 until a cycle with clr_strobe high, and it reads 0 after that edge. The exception is a cycle that is itself losing a result: then the flag stays 1.
- R5: The first rd_strobe after a clr_strobe is a dummy read. It empties the queue, leaves rd_word unchanged, and drops any write in the same cycle. Reads after it behave normally.
- R6: With coding_sel = 0, a read returns the raw 12-bit code zero-extended to 16 bits. The range is 0x0000 to 0x0FFF; for example, raw 0xFFF reads as 0x0FFF.
- R7: With coding_sel = 1, a read returns the raw code minus 2048 as a 16-bit two's complement value. Examples: raw 0x000 reads as 0xF800, raw 0x800 as 0x0000, and raw 0xFFF as 0x07FF.
- R8: A read strobe while the queue is empty, and not a dummy read, leaves rd_word, data_avail and ovf_flag unchanged.
- R9: A write and a read in the same cycle while the queue is full are both served. ovf_flag is not set, and the queue stays full.
- R10: The coding is chosen by the value of coding_sel in the read cycle, not in the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A conversion result is presented this cycle |
| wr_code | input | 12 | Raw conversion result |
| rd_strobe | input | 1 | Host read of the result register |
| clr_strobe | input | 1 | Host write to the clear register |
| coding_sel | input | 1 | 0 = straight binary, 1 = two's complement |
| rd_word | output | 16 | Last result word returned to the host |
| data_avail | output | 1 | At least one result is waiting |
| ovf_flag | output | 1 | Sticky flag: a result was lost to a full queue |

## Verification
The assertions run on every cycle. They check that the fill count never exceeds the depth and that a lossy write raises the overflow flag. They also check that the flag holds without a clear, that a dummy read leaves the queue empty, that an empty read leaves the output word alone, and that a full queue with a read and a write in the same cycle stays full. Other behaviour can only be shown by the bench's scenarios, because it needs a model of the queue contents. That covers the order of returned data, the exact coded value of every one of the 4096 raw codes in both codings, the survival of the stored entries across an overflow, and the effect of flipping the coding select between write and read.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
   typedef enum logic {
      CODE_STRAIGHT = 1'b0,
      CODE_TWOS     = 1'b1
   } code_e;

   typedef struct packed {
      logic push;
      logic pop;
      logic flush;
      logic lose;
   } fifo_op_t;
endpackage

// File: rtl/adcf_ctrl.sv
module adcf_ctrl
   import adcf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             rd_strobe,
   input  logic             clr_strobe,
   output fifo_op_t         op,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             flush_pend
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if ((1 << PTR_W) != DEPTH) begin : g_depth_chk
      $error("DEPTH must be a power of two");
   end

   logic full, empty;
   assign full  = (count == FULL_CNT);
   assign empty = (count == '0);

   always_comb begin
      op.flush = rd_strobe && flush_pend;
      op.pop   = rd_strobe && !flush_pend && !empty;
      op.push  = wr_valid && !op.flush && (!full || op.pop);
      op.lose  = wr_valid && !op.flush && full && !op.pop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr       <= '0;
         rptr       <= '0;
         count      <= '0;
         ovf_flag   <= 1'b0;
         flush_pend <= 1'b0;
      end else begin
         if (op.flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
         end else begin
            if (op.push) wptr <= wptr + 1'b1;
            if (op.pop)  rptr <= rptr + 1'b1;
            if (op.push && !op.pop)      count <= count + 1'b1;
            else if (op.pop && !op.push) count <= count - 1'b1;
         end
         if (op.lose)        ovf_flag <= 1'b1;
         else if (clr_strobe) ovf_flag <= 1'b0;
         if (clr_strobe)      flush_pend <= 1'b1;
         else if (op.flush)   flush_pend <= 1'b0;
      end
   end

   // R2: the fill count never passes the depth
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   // R3: a write into a full queue with no read served raises the flag
   a_r3_lose_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && full && !rd_strobe && !flush_pend) |=> ovf_flag);
   // R4: without a clear the flag never falls
   a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_strobe) |=> ovf_flag);
   // R5: a dummy read leaves the queue empty
   a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && flush_pend) |=> (count == '0));
   // R9: read plus write on a full queue keeps it full
   a_r9_full_both: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && rd_strobe && full && !flush_pend) |=> (count == FULL_CNT));
endmodule

// File: rtl/adcf_store.sv
module adcf_store #(
   parameter int DEPTH = 16,
   parameter int RAW_W = 12,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] wptr,
   input  logic [RAW_W-1:0] wdata,
   input  logic [PTR_W-1:0] rptr,
   output logic [RAW_W-1:0] rdata
);
   logic [DEPTH-1:0][RAW_W-1:0] rows;

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (we && (wptr == PTR_W'(i))) rows[i] <= wdata;
      end
   end

   assign rdata = rows[rptr];
endmodule

// File: rtl/adcf_coder.sv
module adcf_coder
   import adcf_pkg::*;
#(
   parameter int RAW_W = 12,
   parameter int OUT_W = 16,
   localparam int PAD_W = OUT_W - RAW_W
) (
   input  logic [RAW_W-1:0] raw,
   input  code_e            mode,
   output logic [OUT_W-1:0] word
);
   if (RAW_W < 2) begin : g_raw_chk
      $error("RAW_W must be at least 2");
   end
   if (OUT_W < RAW_W) begin : g_out_chk
      $error("OUT_W must not be below RAW_W");
   end

   logic sign_n;
   assign sign_n = ~raw[RAW_W-1];

   if (PAD_W == 0) begin : g_nopad
      always_comb begin
         if (mode == CODE_TWOS) word = {sign_n, raw[RAW_W-2:0]};
         else                   word = raw;
      end
   end else begin : g_pad
      always_comb begin
         if (mode == CODE_TWOS) word = {{PAD_W{sign_n}}, sign_n, raw[RAW_W-2:0]};
         else                   word = {{PAD_W{1'b0}}, raw};
      end
   end
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
   import adcf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int RAW_W = 12,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [RAW_W-1:0] wr_code,
   input  logic             rd_strobe,
   input  logic             clr_strobe,
   input  logic             coding_sel,
   output logic [OUT_W-1:0] rd_word,
   output logic             data_avail,
   output logic             ovf_flag
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   fifo_op_t         op;
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] count;
   logic             flush_pend;
   logic [RAW_W-1:0] head_raw;
   logic [OUT_W-1:0] head_word;
   code_e            mode;

   assign mode = code_e'(coding_sel);

   adcf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_strobe(rd_strobe),
      .clr_strobe(clr_strobe), .op(op), .wptr(wptr), .rptr(rptr),
      .count(count), .ovf_flag(ovf_flag), .flush_pend(flush_pend));

   adcf_store #(.DEPTH(DEPTH), .RAW_W(RAW_W)) store_i (
      .clk(clk), .we(op.push), .wptr(wptr), .wdata(wr_code),
      .rptr(rptr), .rdata(head_raw));

   adcf_coder #(.RAW_W(RAW_W), .OUT_W(OUT_W)) coder_i (
      .raw(head_raw), .mode(mode), .word(head_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_word <= '0;
      else if (op.pop) rd_word <= head_word;
   end

   assign data_avail = (count != '0);

   // R8: an empty read leaves the output word alone
   a_r8_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !data_avail) |=> $stable(rd_word));
   // R5: a dummy read leaves the output word alone
   a_r5_dummy_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && flush_pend) |=> $stable(rd_word));
   // R7: a two's complement read gives a properly sign-extended word
   a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && data_avail && !flush_pend && coding_sel) |=>
      (rd_word[OUT_W-1:RAW_W-1] == '0 || rd_word[OUT_W-1:RAW_W-1] == '1));
endmodule

// File: tb/adc_result_fifo_tb_top.sv
module adc_result_fifo_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [11:0] wr_code = '0;
   logic        rd_strobe = 1'b0;
   logic        clr_strobe = 1'b0;
   logic        coding_sel = 1'b0;
   logic [15:0] rd_word;
   logic        data_avail;
   logic        ovf_flag;

   int errors = 0;
   int checks = 0;

   int          mq[$];
   logic [15:0] m_word = '0;
   logic        m_ovf = 1'b0;
   logic        m_fp = 1'b0;

   always #5 clk = ~clk;

   adc_result_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
      .rd_strobe(rd_strobe), .clr_strobe(clr_strobe), .coding_sel(coding_sel),
      .rd_word(rd_word), .data_avail(data_avail), .ovf_flag(ovf_flag));

   function automatic logic [15:0] expect_word(int code, logic sel);
      int v;
      v = sel ? (code - 2048) : code;
      return 16'(v);
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(string tag, logic w, int code, logic r, logic c, logic sel);
      logic flush, pop, full, lose;
      wr_valid = w; wr_code = 12'(code); rd_strobe = r; clr_strobe = c; coding_sel = sel;
      flush = r && m_fp;
      full  = (mq.size() == 16);
      pop   = r && !m_fp && (mq.size() > 0);
      lose  = 1'b0;
      if (flush) mq.delete();
      else begin
         if (pop) m_word = expect_word(mq.pop_front(), sel);
         if (w) begin
            if (!full || pop) mq.push_back(code);
            else lose = 1'b1;
         end
      end
      if (lose) m_ovf = 1'b1;
      else if (c) m_ovf = 1'b0;
      if (c) m_fp = 1'b1;
      else if (flush) m_fp = 1'b0;
      @(negedge clk);
      wr_valid = 1'b0; rd_strobe = 1'b0; clr_strobe = 1'b0;
      check({tag, " word"}, rd_word, m_word);
      check({tag, " avail"}, 16'(data_avail), 16'(mq.size() > 0));
      check({tag, " ovf"}, 16'(ovf_flag), 16'(m_ovf));
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] held;
      repeat (2) @(negedge clk);
      // R1: reset state
      check("R1 word", rd_word, 16'h0000);
      check("R1 avail", 16'(data_avail), 16'h0);
      check("R1 ovf", 16'(ovf_flag), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 R7 R2: every raw code, both codings, in batches of 16
      for (int s = 0; s < 2; s++) begin
         for (int b = 0; b < 4096; b += 16) begin
            for (int k = 0; k < 16; k++) step("R2 fill", 1'b1, (b + k) ^ (s * 12'h5A5), 1'b0, 1'b0, s[0]);
            for (int k = 0; k < 16; k++) step(s ? "R7 twos" : "R6 straight", 1'b0, 0, 1'b1, 1'b0, s[0]);
         end
      end

      // R7: named corner values
      step("R7 w", 1'b1, 12'h000, 1'b0, 1'b0, 1'b1);
      step("R7 w", 1'b1, 12'h800, 1'b0, 1'b0, 1'b1);
      step("R7 w", 1'b1, 12'hFFF, 1'b0, 1'b0, 1'b1);
      step("R7 r", 1'b0, 0, 1'b1, 1'b0, 1'b1);
      check("R7 0x000", rd_word, 16'hF800);
      step("R7 r", 1'b0, 0, 1'b1, 1'b0, 1'b1);
      check("R7 0x800", rd_word, 16'h0000);
      step("R7 r", 1'b0, 0, 1'b1, 1'b0, 1'b1);
      check("R7 0xFFF", rd_word, 16'h07FF);
      step("R6 w", 1'b1, 12'hFFF, 1'b0, 1'b0, 1'b0);
      step("R6 r", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      check("R6 0xFFF", rd_word, 16'h0FFF);

      // R8: empty read
      held = rd_word;
      step("R8 empty read", 1'b0, 0, 1'b1, 1'b0, 1'b1);
      check("R8 held", rd_word, held);

      // R10: written in straight mode, read in twos mode
      step("R10 w", 1'b1, 12'h123, 1'b0, 1'b0, 1'b0);
      step("R10 r", 1'b0, 0, 1'b1, 1'b0, 1'b1);
      check("R10 recode", rd_word, 16'hF923);

      // R9: full with read and write together
      for (int k = 0; k < 16; k++) step("R9 fill", 1'b1, 100 + k, 1'b0, 1'b0, 1'b0);
      step("R9 both", 1'b1, 777, 1'b1, 1'b0, 1'b0);
      check("R9 no ovf", 16'(ovf_flag), 16'h0);
      for (int k = 0; k < 16; k++) step("R9 drain", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      check("R9 last", rd_word, 16'd777);

      // R3: overflow discards the new result, keeps the stored ones
      for (int k = 0; k < 16; k++) step("R3 fill", 1'b1, 200 + k, 1'b0, 1'b0, 1'b0);
      step("R3 lose", 1'b1, 12'hABC, 1'b0, 1'b0, 1'b0);
      check("R3 ovf", 16'(ovf_flag), 16'h1);
      for (int k = 0; k < 16; k++) step("R3 drain", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      check("R3 last kept", rd_word, 16'd215);

      // R4: sticky, then cleared; clear loses to a same-cycle loss
      for (int k = 0; k < 5; k++) step("R4 hold", 1'b1, k, 1'b0, 1'b0, 1'b0);
      check("R4 still set", 16'(ovf_flag), 16'h1);
      step("R4 clear", 1'b0, 0, 1'b0, 1'b1, 1'b0);
      check("R4 cleared", 16'(ovf_flag), 16'h0);

      // R5: dummy read empties, drops a same-cycle write, keeps word
      held = rd_word;
      step("R5 dummy", 1'b1, 12'h321, 1'b1, 1'b0, 1'b0);
      check("R5 word held", rd_word, held);
      check("R5 empty", 16'(data_avail), 16'h0);
      step("R5 w", 1'b1, 12'h456, 1'b0, 1'b0, 1'b0);
      step("R5 normal", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      check("R5 after", rd_word, 16'h0456);

      // R4: loss and clear in the same cycle keeps the flag
      for (int k = 0; k < 16; k++) step("R4 fill", 1'b1, k, 1'b0, 1'b0, 1'b0);
      step("R4 lose+clr", 1'b1, 9, 1'b0, 1'b1, 1'b0);
      check("R4 loss wins", 16'(ovf_flag), 16'h1);
      step("R4 clr", 1'b0, 0, 1'b0, 1'b1, 1'b0);
      step("R5 dummy2", 1'b0, 0, 1'b1, 1'b0, 1'b0);
      check("R5 empty2", 16'(data_avail), 16'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule